// File: doc/BRIEF.md
# Serial Flash Status Register Write and Protection Controller

This block is the command decoder and status register of a serial NOR flash slave, limited to three commands: write-enable, write-status and read-status. It watches the serial clock, chip select and serial input lines in SPI mode 0. These lines are asynchronous to the block's system clock, so they pass through synchronizers, and their edges are found in the system clock domain. The block keeps an 8-bit status register. It also has a write-protect input.

A status write runs only when the write-enable latch is already set and chip select rises exactly after the sixteenth serial clock. It is also refused when the block is in hardware-protected mode. That mode is the combination of the sticky write-disable bit and a low write-protect input, and the quad-enable bit turns it off. An accepted write starts a self-timed busy interval that lasts a set number of system clocks. During the interval the in-progress bit is set. When the interval ends, the in-progress bit and the write-enable latch both clear.

A read-status command shifts the register out on the serial output, MSB first. It keeps repeating the byte while chip select stays low, and it works during the busy interval too. The register is also brought out as a parallel port so it can be observed.

Top module: `spi_status_reg_ctl`

## Requirements
- R1: After reset the status port reads 0x00 and the serial output is 0.
- R2: Opcode 0x06 with chip select rising after exactly 8 serial clocks sets status bit 1 (write-enable latch) when no write cycle is running.
- R3: Opcode 0x01 followed by one data byte, with chip select rising after exactly 16 clocks and bit 1 set, loads status bits 7..2 from data bits 7..2. Status bits 1 and 0 never take the data's low bits.
- R4: A write-status command issued while bit 1 is 0 leaves the status register unchanged.
- R5: A write-status frame that ends on any clock count other than 16 (for example 12 or 24) is rejected, and the status register, including bit 1, is unchanged.
- R6: An accepted status write sets bit 0 (write in progress) for exactly CYCLE_CLKS system clocks. Bit 0 and bit 1 then both read 0.
- R7: With bit 7 (write-disable) at 1, bit 6 (quad-enable) at 0 and the write-protect input low, write-status is not executed. It makes no difference which of the two conditions arose first.
- R8: With the write-protect input high, a write-status command is executed even when bit 7 is 1. Driving the input high leaves hardware-protected mode.
- R9: With bit 6 at 1, a low write-protect input does not block write-status.
- R10: Opcode 0x05 shifts the status register onto the serial output MSB first, changing after falling serial clock edges. The byte repeats while chip select stays low, and it shows bit 0 at 1 while a write cycle runs.
- R11: While bit 0 is 1, further write-enable and write-status commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from the host |
| wp_n | input | 1 | Active-low write-protect input |
| spi_so | output | 1 | Serial data to the host |
| status_o | output | 8 | Current status register |

## Verification
The assertions check four properties on every system clock. The protect field may change only when the latch was set and hardware-protected mode was off in the cycle before. The latch may rise only while the block is idle. The end of the busy interval must leave the latch clear. The serial output must stay quiet while chip select is high. Other behaviour can only be shown by the bench's scenarios: rejection of frames that end off the byte boundary, the exact length of the busy interval, hardware-protected mode entered in either order, the quad-enable bypass, and the repeating read-out during a write cycle.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_RDSR = 8'h05;

    // serial frame tracking state
    typedef struct packed {
        logic       sclk_prev;
        logic       cs_prev;
        logic [2:0] bit_cnt;
        logic [1:0] byte_cnt;   // saturates at 3
        logic [7:0] shift;
        logic [7:0] opcode;
        logic [7:0] data;
        logic [2:0] out_idx;
        logic [7:0] snap;
        logic       so;
    } frame_st_t;

    // status bits 7..2 and latch
    typedef struct packed {
        logic [5:0] prot;       // [5]=write-disable, [4]=quad-enable, [3:0]=block protect
        logic       wel;
    } ctl_st_t;
endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
    parameter int           WIDTH   = 4,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else if (g == 0) stage_q[g] <= async_i;
                else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_sr_frame.sv
module spi_sr_frame
    import spi_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_s,
    input  logic       cs_n_s,
    input  logic       si_s,
    input  logic [7:0] status_i,
    output logic       end_o,
    output logic       aligned_o,
    output logic [1:0] bytes_o,
    output logic [7:0] opcode_o,
    output logic [7:0] data_o,
    output logic       so_o
);
    frame_st_t st_d, st_q;
    logic      rise, fall;
    logic [7:0] shifted;

    always_comb begin
        st_d    = st_q;
        rise    = sclk_s & ~st_q.sclk_prev & ~cs_n_s;
        fall    = ~sclk_s & st_q.sclk_prev & ~cs_n_s;
        shifted = {st_q.shift[6:0], si_s};
        st_d.sclk_prev = sclk_s;
        st_d.cs_prev   = cs_n_s;
        if (cs_n_s) begin
            st_d.bit_cnt  = '0;
            st_d.byte_cnt = '0;
            st_d.out_idx  = '0;
            st_d.so       = 1'b0;
        end else begin
            if (rise) begin
                st_d.shift   = shifted;
                st_d.bit_cnt = st_q.bit_cnt + 3'd1;
                if (st_q.bit_cnt == 3'd7) begin
                    if (st_q.byte_cnt == 2'd0) st_d.opcode = shifted;
                    else if (st_q.byte_cnt == 2'd1) st_d.data = shifted;
                    if (st_q.byte_cnt != 2'd3) st_d.byte_cnt = st_q.byte_cnt + 2'd1;
                end
            end
            if (fall && st_q.opcode == OP_RDSR && st_q.byte_cnt != 2'd0) begin
                if (st_q.out_idx == 3'd0) begin
                    st_d.snap = status_i;
                    st_d.so   = status_i[7];
                end else begin
                    st_d.so   = st_q.snap[3'd7 - st_q.out_idx];
                end
                st_d.out_idx = st_q.out_idx + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.cs_prev   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign end_o     = cs_n_s & ~st_q.cs_prev;
    assign aligned_o = (st_q.bit_cnt == 3'd0);
    assign bytes_o   = st_q.byte_cnt;
    assign opcode_o  = st_q.opcode;
    assign data_o    = st_q.data;
    assign so_o      = st_q.so;

    // R10: output is quiet once chip select has been seen high
    p_so_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !so_o);
endmodule

// File: rtl/spi_sr_busy_timer.sv
module spi_sr_busy_timer #(
    parameter int CYCLE_CLKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(CYCLE_CLKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLE_CLKS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) cnt_d = LOAD;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == CW'(1));

    // R11: a new cycle never starts on top of a running one
    p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
    // R6: the counter stays within the configured interval
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);
endmodule

// File: rtl/spi_status_reg_ctl.sv
module spi_status_reg_ctl
    import spi_sr_pkg::*;
#(
    parameter int CYCLE_CLKS  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_si,
    input  logic       wp_n,
    output logic       spi_so,
    output logic [7:0] status_o
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] raw, synced;
    logic sclk_s, cs_n_s, si_s, wp_n_s;

    assign raw = {wp_n, spi_si, spi_cs_n, spi_sclk};

    spi_sr_sync #(
        .WIDTH   (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1010)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (synced)
    );

    assign {wp_n_s, si_s, cs_n_s, sclk_s} = synced;

    logic       f_end, f_aligned;
    logic [1:0] f_bytes;
    logic [7:0] f_opcode, f_data;
    logic       busy, done, start;
    ctl_st_t    ctl_d, ctl_q;
    logic       hpm;

    spi_sr_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .cs_n_s    (cs_n_s),
        .si_s      (si_s),
        .status_i  (status_o),
        .end_o     (f_end),
        .aligned_o (f_aligned),
        .bytes_o   (f_bytes),
        .opcode_o  (f_opcode),
        .data_o    (f_data),
        .so_o      (spi_so)
    );

    spi_sr_busy_timer #(
        .CYCLE_CLKS (CYCLE_CLKS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy),
        .done_o  (done)
    );

    always_comb begin
        ctl_d = ctl_q;
        start = 1'b0;
        // write-disable with a low protect pin, unless quad-enable owns the pin
        hpm   = ctl_q.prot[5] & ~wp_n_s & ~ctl_q.prot[4];
        if (done) ctl_d.wel = 1'b0;
        if (f_end && f_aligned && !busy) begin
            if (f_opcode == OP_WREN && f_bytes == 2'd1) ctl_d.wel = 1'b1;
            if (f_opcode == OP_WRSR && f_bytes == 2'd2 && ctl_q.wel && !hpm) begin
                ctl_d.prot = f_data[7:2];
                start      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else ctl_q <= ctl_d;
    end

    assign status_o = {ctl_q.prot, ctl_q.wel, busy};

    // R4: protect field changes only when the latch was set
    p_prot_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q.prot) |-> $past(ctl_q.wel));
    // R7: protect field never changes out of hardware-protected mode
    p_hpm_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q.prot) |-> !$past(hpm));
    // R6: an accepted write is followed by a busy interval
    p_write_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q.prot) |-> busy);
    // R6: end of the busy interval leaves the latch clear
    p_wel_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !ctl_q.wel);
    // R11: latch only rises while idle
    p_wel_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.wel) |-> !$past(busy));
endmodule

// File: tb/sim_spi_status_reg_ctl.sv
module sim_spi_status_reg_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int CYC        = 400;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
    logic       so;
    logic [7:0] status;
    int         checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_status_reg_ctl #(.CYCLE_CLKS(CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_si(si), .wp_n(wp_n), .spi_so(so), .status_o(status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [31:0] w, input int n, output logic [31:0] rx);
        rx = '0;
        cs_n = 1'b1;
        idle(HALF);
        cs_n = 1'b0;
        idle(HALF);
        for (int i = 0; i < n; i++) begin
            si = w[n-1-i];
            idle(HALF);
            rx = {rx[30:0], so};
            sclk = 1'b1;
            idle(HALF);
            sclk = 1'b0;
        end
        idle(HALF);
        cs_n = 1'b1;
    endtask

    task automatic cmd(input logic [31:0] w, input int n);
        logic [31:0] rx;
        spi_bits(w, n, rx);
    endtask

    task automatic wren();
        cmd(32'h06, 8);
        idle(10);
    endtask

    task automatic wrsr_wait(input logic [7:0] d);
        cmd({16'h0, 8'h01, d}, 16);
        idle(CYC + 50);
    endtask

    task automatic t_reset();
        check("R1 status after reset", status, 8'h00);
        check("R1 so after reset", so, 1'b0);
    endtask

    task automatic t_wren();
        wren();
        check("R2 wel set", status, 8'h02);
    endtask

    task automatic t_write_basic();
        int ones = 0;
        cmd(32'h015B, 16);
        for (int i = 0; i < CYC + 50; i++) begin
            @(negedge clk);
            if (status[0]) ones++;
        end
        check("R6 wip length", ones, CYC);
        check("R3 R6 bits loaded, wel/wip clear", status, 8'h58);
    endtask

    task automatic t_read_during_wip();
        logic [31:0] rx;
        wren();
        cmd(32'h0114, 16);
        idle(10);
        spi_bits(32'h050000, 24, rx);
        check("R10 read byte during wip", rx[15:8], 8'h17);
        check("R10 repeated byte", rx[7:0], 8'h17);
        idle(CYC + 50);
        spi_bits(32'h0500, 16, rx);
        check("R10 read after cycle", rx[7:0], 8'h14);
        wren();
        wrsr_wait(8'h00);
        check("R3 restore", status, 8'h00);
    endtask

    task automatic t_no_wel();
        cmd(32'h013C, 16);
        idle(20);
        check("R4 write without wel", status, 8'h00);
    endtask

    task automatic t_misalign();
        wren();
        cmd(32'h0153, 12);
        idle(20);
        check("R5 12-bit frame rejected", status, 8'h02);
        cmd(32'h013C00, 24);
        idle(20);
        check("R5 24-bit frame rejected", status, 8'h02);
    endtask

    task automatic t_protect();
        wrsr_wait(8'h80);
        check("R8 srwd set", status, 8'h80);
        wren();
        wp_n = 1'b0;
        cmd(32'h013C, 16);
        idle(20);
        check("R7 hpm blocks write", status, 8'h82);
        wp_n = 1'b1;
        idle(10);
        wrsr_wait(8'h3C);
        check("R8 wp high allows write", status, 8'h3C);
        wp_n = 1'b0;
        wren();
        wrsr_wait(8'h80);
        check("R7 srwd set with wp low", status, 8'h80);
        wren();
        cmd(32'h0100, 16);
        idle(20);
        check("R7 hpm entered pin first", status, 8'h82);
        wp_n = 1'b1;
        idle(10);
        wrsr_wait(8'h00);
        check("R8 exit hpm", status, 8'h00);
    endtask

    task automatic t_quad();
        wren();
        wrsr_wait(8'hC0);
        check("R9 qe and srwd set", status, 8'hC0);
        wp_n = 1'b0;
        wren();
        wrsr_wait(8'h04);
        check("R9 qe bypasses pin", status, 8'h04);
        wp_n = 1'b1;
    endtask

    task automatic t_busy_ignore();
        wren();
        cmd(32'h0114, 16);
        cmd(32'h0128, 16);
        idle(CYC + 50);
        check("R11 write during wip ignored", status, 8'h14);
        wren();
        cmd(32'h0100, 16);
        cmd(32'h06, 8);
        idle(CYC + 50);
        check("R11 wren during wip ignored", status, 8'h00);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(5);
        t_reset();
        t_wren();
        t_write_basic();
        t_read_during_wip();
        t_no_wel();
        t_misalign();
        t_protect();
        t_quad();
        t_busy_ignore();
        finish_run();
    end
endmodule